// File: doc/BRIEF.md
# Operand Bypass and Interlock Unit

This unit settles every data dependency of a five-stage in-order pipeline (fetch, operand fetch, execute, memory, writeback) while the consumer is still in operand fetch. It carries a small tag for each instruction in execute, memory and writeback: valid bit, write enable, destination index and result class. The class says how early a result can be handed back. Execute-ready results (integer arithmetic, logic, single-bit shifts, stream reads) can be taken from execute. Memory-ready results (barrel shift, divide) can be taken from memory onward. Every other class (loads, multiplies, floating point) can be taken only from writeback.

For each of three source fields in operand fetch (ALU operand A, ALU operand B and store data), the unit picks a source: the register file, the execute result, the memory result or the writeback result. It drives that operand value out. When no source is ready yet, it raises an interlock that holds fetch and operand fetch and sends a bubble into execute. A busy input from the memory stage, used by multi-cycle operations such as divide, freezes execute and memory in place, holds fetch and operand fetch, and sends an empty slot into writeback. The decoder, ALU, register file and memory port sit outside the unit.

Each cycle falls into one of three pipeline modes, each decoded by a unique case. MODE_FLOW: nothing holds. MODE_INTERLOCK: a dependency is not ready, so operand fetch holds and execute gets a bubble. MODE_FREEZE: memory is busy, so every stage from memory back to fetch holds. Freeze takes precedence over interlock. Each cycle is classified afresh from the current tags and inputs, so the mode moves FLOW→INTERLOCK when an unready producer sits ahead of the consumer. It moves INTERLOCK→FLOW once that producer reaches a stage it may forward from. It enters FREEZE from any mode when busy rises, and leaves FREEZE once busy falls.

Top module: `opfwd_interlock`

## Requirements
- R1: While reset is low, and after it is released with no instruction issued, ex_valid, mem_valid and wb_we are low and of_hold is low.
- R2: A producer of class 0 (execute-ready) in execute whose destination matches an enabled source is forwarded with select code 1, and the operand equals ex_result with no interlock. An add followed by a store of its result issues with zero stall cycles.
- R3: A producer of class 1 (memory-ready) in execute interlocks a matching consumer. Once that producer is in memory, the consumer takes select code 2 with the operand equal to mem_result, one stall cycle in all.
- R4: A producer of class 2 or 3 (writeback-only) interlocks a matching consumer while it is in execute or memory. It is forwarded with select code 3 and operand wb_result once it is in writeback. Load, load, add using the second load gives stalls 0, 0, 2, and multiply followed by a store of its result gives 2 stalls.
- R5: When several stages hold the same destination, the youngest valid writer wins, checked in the order execute, memory, writeback. An unready younger writer interlocks even if an older ready writer exists.
- R6: Source index 0 yields select code 0 and operand value 0 and never interlocks. Producers with write enable low or valid low never match.
- R7: A source field whose enable is low never interlocks and gives select code 0.
- R8: During an interlock (of_hold and ex_bubble high), the next cycle has execute empty while the execute tag moves on to memory.
- R9: While mem_busy is high, of_hold and pipe_freeze are high and ex_bubble is low. Execute and memory tags keep their value across the edge, and writeback is empty after it.
- R10: The operand value equals the register file read data for select 0, ex_result for 1, mem_result for 2 and wb_result for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| of_valid | input | 1 | Operand-fetch slot holds an instruction |
| of_wen | input | 1 | That instruction writes a register |
| of_dst | input | 5 | Its destination index |
| of_cls | input | 2 | Its result class: 0 execute-ready, 1 memory-ready, 2/3 writeback-only |
| of_src_a | input | 5 | Operand A source index |
| of_src_a_en | input | 1 | Operand A is used |
| of_src_b | input | 5 | Operand B source index |
| of_src_b_en | input | 1 | Operand B is used |
| of_src_s | input | 5 | Store-data source index |
| of_src_s_en | input | 1 | Store data is used |
| rf_data_a | input | XLEN | Register file read for operand A |
| rf_data_b | input | XLEN | Register file read for operand B |
| rf_data_s | input | XLEN | Register file read for store data |
| ex_result | input | XLEN | Result leaving the execute stage |
| mem_result | input | XLEN | Result held in the memory stage |
| wb_result | input | XLEN | Result being written back |
| mem_busy | input | 1 | Memory stage is still working on a multi-cycle result |
| op_a | output | XLEN | Resolved operand A |
| op_b | output | XLEN | Resolved operand B |
| op_s | output | XLEN | Resolved store data |
| sel_a | output | 2 | Operand A source: 0 register file, 1 execute, 2 memory, 3 writeback |
| sel_b | output | 2 | Operand B source, same coding |
| sel_s | output | 2 | Store-data source, same coding |
| of_hold | output | 1 | Hold fetch and operand fetch |
| ex_bubble | output | 1 | Load an empty slot into execute |
| pipe_freeze | output | 1 | Hold execute and memory, empty writeback |
| ex_valid | output | 1 | Execute stage occupied |
| mem_valid | output | 1 | Memory stage occupied |
| wb_we | output | 1 | Writeback writes the register file this cycle |
| wb_dst | output | 5 | Register written back |

## Verification
The hardest case to reach is a memory-stage freeze that overlaps a pending dependency. The dividing producer must sit in memory, an unrelated instruction in execute, a different writer in writeback and the consumer in operand fetch, all in the same cycle. The stimulus issues a writer, a memory-ready divide and an independent instruction back to back, then presents the consumer and raises mem_busy at once. It then checks that writeback empties, that memory stays occupied, and that after release the consumer takes the divide result from memory without an extra stall.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    localparam int unsigned REG_IDX_W = 5;

    typedef enum logic [1:0] {
        CLS_EX     = 2'd0,
        CLS_MEM    = 2'd1,
        CLS_WB     = 2'd2,
        CLS_WB_ALT = 2'd3
    } res_cls_e;

    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2,
        SEL_WB  = 2'd3
    } opsel_e;

    typedef enum logic [1:0] {
        MODE_FLOW      = 2'd0,
        MODE_INTERLOCK = 2'd1,
        MODE_FREEZE    = 2'd2
    } pipe_mode_e;

    typedef struct packed {
        logic                 valid;
        logic                 wen;
        logic [REG_IDX_W-1:0] dst;
        res_cls_e             cls;
    } stage_tag_t;

endpackage

// File: rtl/opfwd_stage_track.sv
module opfwd_stage_track
    import opfwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_tag_t of_tag,
    input  logic       ex_bubble,
    input  logic       pipe_freeze,
    output stage_tag_t ex_q,
    output stage_tag_t mem_q,
    output stage_tag_t wb_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q  <= '0;
            mem_q <= '0;
            wb_q  <= '0;
        end else if (pipe_freeze) begin
            // execute and memory hold; writeback receives an empty slot
            wb_q <= '0;
        end else begin
            wb_q  <= mem_q;
            mem_q <= ex_q;
            ex_q  <= ex_bubble ? '0 : of_tag;
        end
    end

endmodule

// File: rtl/opfwd_field_resolve.sv
module opfwd_field_resolve
    import opfwd_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                 en,
    input  logic [REG_IDX_W-1:0] src,
    input  logic [XLEN-1:0]      rf_data,
    input  stage_tag_t           ex_tag,
    input  stage_tag_t           mem_tag,
    input  stage_tag_t           wb_tag,
    input  logic [XLEN-1:0]      ex_res,
    input  logic [XLEN-1:0]      mem_res,
    input  logic [XLEN-1:0]      wb_res,
    output opsel_e               sel,
    output logic [XLEN-1:0]      data,
    output logic                 hazard
);

    function automatic logic writes_reg(stage_tag_t t, logic [REG_IDX_W-1:0] r);
        return t.valid && t.wen && (t.dst == r);
    endfunction

    logic live;
    assign live = en && (src != '0);

    // youngest writer first: execute, then memory, then writeback
    always_comb begin
        sel    = SEL_RF;
        hazard = 1'b0;
        if (live) begin
            if (writes_reg(ex_tag, src)) begin
                if (ex_tag.cls == CLS_EX) sel = SEL_EX;
                else                      hazard = 1'b1;
            end else if (writes_reg(mem_tag, src)) begin
                if (mem_tag.cls == CLS_EX || mem_tag.cls == CLS_MEM) sel = SEL_MEM;
                else                                                  hazard = 1'b1;
            end else if (writes_reg(wb_tag, src)) begin
                sel = SEL_WB;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_RF:  data = (src == '0) ? '0 : rf_data;
            SEL_EX:  data = ex_res;
            SEL_MEM: data = mem_res;
            SEL_WB:  data = wb_res;
        endcase
    end

endmodule

// File: rtl/opfwd_pipe_ctrl.sv
module opfwd_pipe_ctrl
    import opfwd_pkg::*;
#(
    parameter int unsigned NFIELD = 3
) (
    input  logic [NFIELD-1:0] field_hazard,
    input  logic              mem_busy,
    output logic              of_hold,
    output logic              ex_bubble,
    output logic              pipe_freeze
);

    pipe_mode_e mode;

    always_comb begin
        if (mem_busy)           mode = MODE_FREEZE;
        else if (|field_hazard) mode = MODE_INTERLOCK;
        else                    mode = MODE_FLOW;
    end

    always_comb begin
        unique case (mode)
            MODE_FLOW: begin
                of_hold     = 1'b0;
                ex_bubble   = 1'b0;
                pipe_freeze = 1'b0;
            end
            MODE_INTERLOCK: begin
                of_hold     = 1'b1;
                ex_bubble   = 1'b1;
                pipe_freeze = 1'b0;
            end
            MODE_FREEZE: begin
                of_hold     = 1'b1;
                ex_bubble   = 1'b0;
                pipe_freeze = 1'b1;
            end
            default: begin
                of_hold     = 1'b1;
                ex_bubble   = 1'b0;
                pipe_freeze = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/opfwd_interlock.sv
module opfwd_interlock
    import opfwd_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 of_valid,
    input  logic                 of_wen,
    input  logic [REG_IDX_W-1:0] of_dst,
    input  logic [1:0]           of_cls,
    input  logic [REG_IDX_W-1:0] of_src_a,
    input  logic                 of_src_a_en,
    input  logic [REG_IDX_W-1:0] of_src_b,
    input  logic                 of_src_b_en,
    input  logic [REG_IDX_W-1:0] of_src_s,
    input  logic                 of_src_s_en,
    input  logic [XLEN-1:0]      rf_data_a,
    input  logic [XLEN-1:0]      rf_data_b,
    input  logic [XLEN-1:0]      rf_data_s,
    input  logic [XLEN-1:0]      ex_result,
    input  logic [XLEN-1:0]      mem_result,
    input  logic [XLEN-1:0]      wb_result,
    input  logic                 mem_busy,
    output logic [XLEN-1:0]      op_a,
    output logic [XLEN-1:0]      op_b,
    output logic [XLEN-1:0]      op_s,
    output logic [1:0]           sel_a,
    output logic [1:0]           sel_b,
    output logic [1:0]           sel_s,
    output logic                 of_hold,
    output logic                 ex_bubble,
    output logic                 pipe_freeze,
    output logic                 ex_valid,
    output logic                 mem_valid,
    output logic                 wb_we,
    output logic [REG_IDX_W-1:0] wb_dst
);

    localparam int unsigned NFIELD = 3;

    stage_tag_t of_tag, ex_q, mem_q, wb_q;

    assign of_tag = '{valid: of_valid, wen: of_wen, dst: of_dst, cls: res_cls_e'(of_cls)};

    opfwd_stage_track i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .of_tag     (of_tag),
        .ex_bubble  (ex_bubble),
        .pipe_freeze(pipe_freeze),
        .ex_q       (ex_q),
        .mem_q      (mem_q),
        .wb_q       (wb_q)
    );

    logic [REG_IDX_W-1:0] f_src [NFIELD];
    logic                 f_en  [NFIELD];
    logic [XLEN-1:0]      f_rf  [NFIELD];
    opsel_e               f_sel [NFIELD];
    logic [XLEN-1:0]      f_op  [NFIELD];
    logic [NFIELD-1:0]    f_haz;

    assign f_src[0] = of_src_a;  assign f_en[0] = of_valid && of_src_a_en;  assign f_rf[0] = rf_data_a;
    assign f_src[1] = of_src_b;  assign f_en[1] = of_valid && of_src_b_en;  assign f_rf[1] = rf_data_b;
    assign f_src[2] = of_src_s;  assign f_en[2] = of_valid && of_src_s_en;  assign f_rf[2] = rf_data_s;

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        opfwd_field_resolve #(.XLEN(XLEN)) i_resolve (
            .en     (f_en[g]),
            .src    (f_src[g]),
            .rf_data(f_rf[g]),
            .ex_tag (ex_q),
            .mem_tag(mem_q),
            .wb_tag (wb_q),
            .ex_res (ex_result),
            .mem_res(mem_result),
            .wb_res (wb_result),
            .sel    (f_sel[g]),
            .data   (f_op[g]),
            .hazard (f_haz[g])
        );
    end

    opfwd_pipe_ctrl #(.NFIELD(NFIELD)) i_ctrl (
        .field_hazard(f_haz),
        .mem_busy    (mem_busy),
        .of_hold     (of_hold),
        .ex_bubble   (ex_bubble),
        .pipe_freeze (pipe_freeze)
    );

    assign op_a  = f_op[0];
    assign op_b  = f_op[1];
    assign op_s  = f_op[2];
    assign sel_a = f_sel[0];
    assign sel_b = f_sel[1];
    assign sel_s = f_sel[2];

    assign ex_valid  = ex_q.valid;
    assign mem_valid = mem_q.valid;
    assign wb_we     = wb_q.valid && wb_q.wen;
    assign wb_dst    = wb_q.dst;

endmodule

// File: rtl/opfwd_interlock_chk.sv
module opfwd_interlock_chk
    import opfwd_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 of_valid,
    input logic [REG_IDX_W-1:0] of_src_a,
    input logic                 of_src_a_en,
    input logic [1:0]           sel_a,
    input logic [XLEN-1:0]      op_a,
    input logic [XLEN-1:0]      ex_result,
    input logic [XLEN-1:0]      wb_result,
    input logic                 mem_busy,
    input logic                 of_hold,
    input logic                 ex_bubble,
    input logic                 pipe_freeze,
    input logic                 ex_valid,
    input logic                 mem_valid,
    input logic                 wb_we,
    input stage_tag_t           ex_tag,
    input stage_tag_t           mem_tag
);

    logic a_hits_ex;
    assign a_hits_ex = of_valid && of_src_a_en && (of_src_a != '0) &&
                       ex_tag.valid && ex_tag.wen && (ex_tag.dst == of_src_a);

    assert_ex_ready_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        a_hits_ex && ex_tag.cls == CLS_EX |-> sel_a == 2'd1 && !ex_bubble);

    assert_mem_ready_interlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        a_hits_ex && ex_tag.cls == CLS_MEM |-> of_hold);

    assert_zero_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        of_src_a == '0 |-> sel_a == 2'd0 && op_a == '0);

    assert_disabled_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !of_src_a_en |-> sel_a == 2'd0);

    assert_bubble_empties_ex_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> !ex_valid);

    assert_bubble_advances_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> mem_valid == $past(ex_valid));

    assert_busy_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy |-> of_hold && pipe_freeze && !ex_bubble);

    assert_freeze_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_freeze |=> $stable(ex_tag) && $stable(mem_tag) && !wb_we);

    assert_wb_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a == 2'd3 |-> op_a == wb_result);

    assert_ex_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a == 2'd1 |-> op_a == ex_result);

endmodule

bind opfwd_interlock opfwd_interlock_chk #(.XLEN(XLEN)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .of_valid   (of_valid),
    .of_src_a   (of_src_a),
    .of_src_a_en(of_src_a_en),
    .sel_a      (sel_a),
    .op_a       (op_a),
    .ex_result  (ex_result),
    .wb_result  (wb_result),
    .mem_busy   (mem_busy),
    .of_hold    (of_hold),
    .ex_bubble  (ex_bubble),
    .pipe_freeze(pipe_freeze),
    .ex_valid   (ex_valid),
    .mem_valid  (mem_valid),
    .wb_we      (wb_we),
    .ex_tag     (ex_q),
    .mem_tag    (mem_q)
);

// File: tb/test_opfwd_interlock.sv
module test_opfwd_interlock;

    localparam int XLEN = 32;
    localparam logic [31:0] K_RFA = 32'hA0A0_0001;
    localparam logic [31:0] K_RFB = 32'hB0B0_0002;
    localparam logic [31:0] K_RFS = 32'hC0C0_0003;
    localparam logic [31:0] K_EX  = 32'h1111_1111;
    localparam logic [31:0] K_MEM = 32'h2222_2222;
    localparam logic [31:0] K_WB  = 32'h3333_3333;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic of_valid = 1'b0, of_wen = 1'b0;
    logic [4:0] of_dst = '0, of_src_a = '0, of_src_b = '0, of_src_s = '0;
    logic [1:0] of_cls = '0;
    logic of_src_a_en = 1'b0, of_src_b_en = 1'b0, of_src_s_en = 1'b0;
    logic mem_busy = 1'b0;
    logic [XLEN-1:0] op_a, op_b, op_s;
    logic [1:0] sel_a, sel_b, sel_s;
    logic of_hold, ex_bubble, pipe_freeze, ex_valid, mem_valid, wb_we;
    logic [4:0] wb_dst;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    opfwd_interlock #(.XLEN(XLEN)) i_opfwd_interlock (
        .clk(clk), .rst_n(rst_n),
        .of_valid(of_valid), .of_wen(of_wen), .of_dst(of_dst), .of_cls(of_cls),
        .of_src_a(of_src_a), .of_src_a_en(of_src_a_en),
        .of_src_b(of_src_b), .of_src_b_en(of_src_b_en),
        .of_src_s(of_src_s), .of_src_s_en(of_src_s_en),
        .rf_data_a(K_RFA), .rf_data_b(K_RFB), .rf_data_s(K_RFS),
        .ex_result(K_EX), .mem_result(K_MEM), .wb_result(K_WB),
        .mem_busy(mem_busy),
        .op_a(op_a), .op_b(op_b), .op_s(op_s),
        .sel_a(sel_a), .sel_b(sel_b), .sel_s(sel_s),
        .of_hold(of_hold), .ex_bubble(ex_bubble), .pipe_freeze(pipe_freeze),
        .ex_valid(ex_valid), .mem_valid(mem_valid), .wb_we(wb_we), .wb_dst(wb_dst)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        of_valid = 1'b0; of_wen = 1'b0;
        of_src_a_en = 1'b0; of_src_b_en = 1'b0; of_src_s_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // entered at a falling edge; returns at the falling edge after acceptance
    task automatic issue(input logic [4:0] dst, input logic wen, input logic [1:0] cls,
                         input logic [4:0] sa, input logic ea,
                         input logic [4:0] sb, input logic eb,
                         input logic [4:0] ss, input logic es,
                         output int nst, output logic [1:0] ga, gb, gs,
                         output logic [31:0] va, vb, vs, output logic exv);
        of_valid = 1'b1; of_wen = wen; of_dst = dst; of_cls = cls;
        of_src_a = sa; of_src_a_en = ea;
        of_src_b = sb; of_src_b_en = eb;
        of_src_s = ss; of_src_s_en = es;
        nst = 0;
        #1;
        while (of_hold && nst < 50) begin
            nst++;
            @(negedge clk); #1;
        end
        ga = sel_a; gb = sel_b; gs = sel_s;
        va = op_a; vb = op_b; vs = op_s; exv = ex_valid;
        @(negedge clk);
    endtask

    int n; logic [1:0] ga, gb, gs; logic [31:0] va, vb, vs; logic exv;

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check_eq("R1", "ex_valid in reset", ex_valid, 0);
        check_eq("R1", "wb_we in reset", wb_we, 0);
        rst_n = 1'b1;
        idle(2); #1;
        check_eq("R1", "mem_valid after reset", mem_valid, 0);
        check_eq("R1", "of_hold after reset", of_hold, 0);
        @(negedge clk);
    endtask

    task automatic t_load_load_add;
        idle(3);
        issue(5'd4, 1, 2'd2, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R4", "first load stalls", n, 0);
        issue(5'd3, 1, 2'd2, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R4", "second load stalls", n, 0);
        issue(5'd3, 1, 2'd0, 5'd4, 1, 5'd3, 1, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R4", "add after load stalls", n, 2);
        check_eq("R4", "add operand B select", gb, 3);
        check_eq("R10", "add operand B value", vb, K_WB);
        check_eq("R10", "add operand A from regfile", va, K_RFA);
        check_eq("R8", "execute empty after interlock", exv, 0);
    endtask

    task automatic t_add_store;
        idle(3);
        issue(5'd7, 1, 2'd0, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd0, 0, 2'd0, 5'd1, 1, 0, 0, 5'd7, 1, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R2", "store after add stalls", n, 0);
        check_eq("R2", "store data select", gs, 1);
        check_eq("R10", "store data value", vs, K_EX);
    endtask

    task automatic t_mul_store;
        idle(3);
        issue(5'd8, 1, 2'd3, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd0, 0, 2'd0, 0, 0, 0, 0, 5'd8, 1, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R4", "store after multiply stalls", n, 2);
        check_eq("R4", "store data select", gs, 3);
    endtask

    task automatic t_shift_use;
        idle(3);
        issue(5'd10, 1, 2'd1, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd2, 1, 2'd0, 5'd10, 1, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R3", "consumer of shift stalls", n, 1);
        check_eq("R3", "consumer select", ga, 2);
        check_eq("R10", "consumer value", va, K_MEM);
        check_eq("R8", "execute empty after one-cycle interlock", exv, 0);
    endtask

    task automatic t_priority;
        idle(3);
        repeat (3) issue(5'd5, 1, 2'd0, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd2, 1, 2'd0, 5'd5, 1, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R5", "three writers, select youngest", ga, 1);
        check_eq("R5", "three writers, no stall", n, 0);
        idle(3);
        issue(5'd5, 1, 2'd0, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd5, 1, 2'd2, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd2, 1, 2'd0, 5'd5, 1, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R5", "unready younger writer stalls", n, 2);
        check_eq("R5", "taken from younger writer in writeback", ga, 3);
    endtask

    task automatic t_zero_and_ignored;
        idle(3);
        issue(5'd0, 1, 2'd2, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd2, 1, 2'd0, 5'd0, 1, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R6", "register 0 no stall", n, 0);
        check_eq("R6", "register 0 select", ga, 0);
        check_eq("R6", "register 0 value", va, 0);
        idle(3);
        issue(5'd7, 0, 2'd2, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd2, 1, 2'd0, 0, 0, 5'd7, 1, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R6", "non-writing producer no stall", n, 0);
        check_eq("R6", "non-writing producer value", vb, K_RFB);
    endtask

    task automatic t_field_enable;
        idle(3);
        issue(5'd9, 1, 2'd2, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd2, 1, 2'd0, 5'd9, 0, 5'd9, 0, 5'd9, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R7", "disabled fields no stall", n, 0);
        check_eq("R7", "disabled field select", gb, 0);
        idle(3);
        issue(5'd9, 1, 2'd2, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd2, 1, 2'd0, 0, 0, 5'd9, 1, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        check_eq("R7", "enabled field does stall", n, 2);
    endtask

    task automatic t_freeze;
        idle(3);
        issue(5'd6, 1, 2'd0, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd11, 1, 2'd1, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        issue(5'd12, 1, 2'd0, 0, 0, 0, 0, 0, 0, n, ga, gb, gs, va, vb, vs, exv);
        of_valid = 1'b1; of_wen = 1'b1; of_dst = 5'd13; of_cls = 2'd0;
        of_src_a = 5'd11; of_src_a_en = 1'b1;
        mem_busy = 1'b1;
        #1;
        check_eq("R9", "freeze holds operand fetch", of_hold, 1);
        check_eq("R9", "freeze sends no bubble", ex_bubble, 0);
        check_eq("R9", "freeze flag", pipe_freeze, 1);
        check_eq("R9", "writer in writeback before freeze edge", wb_we, 1);
        @(negedge clk); #1;
        check_eq("R9", "writeback emptied by freeze", wb_we, 0);
        check_eq("R9", "memory stays occupied", mem_valid, 1);
        check_eq("R9", "execute stays occupied", ex_valid, 1);
        @(negedge clk);
        mem_busy = 1'b0;
        #1;
        check_eq("R3", "divide result after release, no stall", of_hold, 0);
        check_eq("R3", "divide result select", sel_a, 2);
        check_eq("R10", "divide result value", op_a, K_MEM);
        @(negedge clk);
        idle(3);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load_load_add();
        t_add_store();
        t_mul_store();
        t_shift_use();
        t_priority();
        t_zero_and_ignored();
        t_field_enable();
        t_freeze();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule